// File: doc/BRIEF.md
# March C+ Test Sequencer

This block runs a March C+ test on a single synchronous RAM port. An outside address generator keeps the word address. The sequencer tells it when to load a start address and in which direction to run, and when to step. The generator answers with an expire flag when it sits on the last address of the current pass. For each March element the sequencer issues the element's reads and writes on the RAM port. The data word is a 4-bit seed repeated across the whole word, or the bitwise inverse of that word. Every read result is compared against the value the algorithm expects.

Each RAM operation occupies a programmed number of cycles. Reads and writes are programmed separately, and each field holds the cycle count minus one. A read result is compared in the cycle in which it becomes valid, that is the read latency in cycles after the enable. A mismatch sets a sticky fail flag and accumulates the failing bit positions. When the last element ends the block raises done. Pass or fail is then read from the status outputs. A fast-index select chooses whether the generator moves the X or the Y part of the address fastest. It is latched at start and passed to the generator.

Top module: `march_seq_engine`

## Requirements
- R1: Every write carries either the latched 4-bit seed copied into all 16 nibbles of the 64-bit word, or the bitwise inverse of that word.
- R2: The test runs six elements in this order: up w0; up r0,w1,r1; up r1,w0,r0; down r0,w1,r1; down r1,w0,r0; up r0. Here 0 is the seed word and 1 is its inverse. For a W-word RAM that gives 9W reads and 5W writes. Each element starts with a one-cycle address load pulse, with addr_down=1 for "down". After an element's last operation on an address, addr_step is pulsed while addr_expire is low. When addr_expire is high, the sequencer moves on to the next element instead.
- R3: A read occupies rd_lat+1 cycles and a write occupies wr_lat+1 cycles, with ram_ce high only in the first of them. From start to done, busy stays high for exactly 7 + W*(9*(rd_lat+1) + 5*(wr_lat+1)) cycles.
- R4: Read data is compared during the cycle that lies rd_lat+1 cycles after the cycle in which ram_ce was high for that read. Data outside that cycle has no effect.
- R5: A read mismatch sets fail, and fail stays set until the next start. The XOR of the read word and the expected word is ORed into fail_bits. pass is high only while done is high and fail is low.
- R6: done rises when the final read has been compared and stays high until the next start. busy is low while done is high.
- R7: run starts a test only when the block is idle or done. While busy is high, run is ignored, and changes on seed, rd_lat, wr_lat and fast_sel have no effect on the running test.
- R8: fast_y holds the value of fast_sel latched at start.
- R9: Reset clears busy, done, pass, fail and fail_bits and keeps ram_ce low, even in the middle of a test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start request |
| seed | input | 4 | Data seed |
| rd_lat | input | 4 | Read cycles minus one |
| wr_lat | input | 4 | Write cycles minus one |
| fast_sel | input | 1 | Fast-index select (1: Y fast) |
| fast_y | output | 1 | Latched fast-index select for the generator |
| addr_load | output | 1 | Load start address |
| addr_down | output | 1 | Direction of the current element |
| addr_step | output | 1 | Advance the address |
| addr_expire | input | 1 | Generator is on the last address of this pass |
| ram_ce | output | 1 | RAM operation issue |
| ram_we | output | 1 | Operation is a write |
| ram_wdata | output | 64 | Write data |
| ram_rdata | input | 64 | Read data |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Sticky mismatch flag |
| fail_bits | output | 64 | Accumulated failing bit positions |

## Verification
The hardest case to reach is a read that returns the wrong value in exactly one cycle, the cycle in which the block compares it. The bench RAM model delays each read by the programmed latency and drives a fixed non-pattern word in every other cycle, so a compare taken one cycle off shows up as a false failure. A single stuck bit is injected at a random address and bit position. It must appear as exactly that one bit in fail_bits, across random seeds, latencies and fast-index settings. Several runs also get a run pulse and new configuration values in the middle of the test.

// File: rtl/march_seq_engine.sv
module march_seq_engine #(
  parameter int SEED_W = 4,
  parameter int WORD_W = 64,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SEED_W-1:0] seed,
  input  logic [LAT_W-1:0]  rd_lat,
  input  logic [LAT_W-1:0]  wr_lat,
  input  logic              fast_sel,
  output logic              fast_y,
  output logic              addr_load,
  output logic              addr_down,
  output logic              addr_step,
  input  logic              addr_expire,
  output logic              ram_ce,
  output logic              ram_we,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [WORD_W-1:0] fail_bits
);
  localparam int REP = WORD_W / SEED_W;
  localparam logic [2:0] LAST_ELEM = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_OP, S_FLUSH, S_DONE} state_t;

  state_t            state;
  logic [2:0]        elem;
  logic [1:0]        idx;
  logic [LAT_W-1:0]  cnt, rlat_q, wlat_q;
  logic [SEED_W-1:0] seed_q;
  logic              chk_pend, chk_inv;

  wire [WORD_W-1:0] pat      = {REP{seed_q}};
  wire              single   = (elem == 3'd0) || (elem == LAST_ELEM);
  wire [1:0]        last_idx = single ? 2'd0 : 2'd2;
  wire              cur_wr   = (elem == 3'd0) || (!single && idx == 2'd1);
  wire              cur_inv  = (elem == 3'd1 || elem == 3'd3) ? (idx != 2'd0) :
                               (elem == 3'd2 || elem == 3'd4) ? (idx == 2'd0) : 1'b0;
  wire [LAT_W-1:0]  cur_lat  = cur_wr ? wlat_q : rlat_q;
  wire              op_end   = (state == S_OP) && (cnt == cur_lat);
  wire              last_op  = (idx == last_idx);
  wire              start    = run && (state == S_IDLE || state == S_DONE);
  wire [WORD_W-1:0] diff     = ram_rdata ^ (chk_inv ? ~pat : pat);

  assign addr_load = (state == S_LOAD);
  assign addr_down = (elem == 3'd3) || (elem == 3'd4);
  assign addr_step = op_end && last_op && !addr_expire;
  assign ram_ce    = (state == S_OP) && (cnt == '0);
  assign ram_we    = ram_ce && cur_wr;
  assign ram_wdata = cur_inv ? ~pat : pat;
  assign busy      = (state == S_LOAD) || (state == S_OP) || (state == S_FLUSH);
  assign done      = (state == S_DONE);
  assign pass      = done && !fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      elem      <= '0;
      idx       <= '0;
      cnt       <= '0;
      rlat_q    <= '0;
      wlat_q    <= '0;
      seed_q    <= '0;
      fast_y    <= 1'b0;
      chk_pend  <= 1'b0;
      chk_inv   <= 1'b0;
      fail      <= 1'b0;
      fail_bits <= '0;
    end else begin
      chk_pend <= 1'b0;
      if (chk_pend) begin
        fail_bits <= fail_bits | diff;
        if (diff != '0) fail <= 1'b1;
      end
      if (op_end && !cur_wr) begin
        chk_pend <= 1'b1;
        chk_inv  <= cur_inv;
      end
      case (state)
        S_IDLE, S_DONE: if (start) begin
          seed_q    <= seed;
          rlat_q    <= rd_lat;
          wlat_q    <= wr_lat;
          fast_y    <= fast_sel;
          fail      <= 1'b0;
          fail_bits <= '0;
          elem      <= '0;
          idx       <= '0;
          cnt       <= '0;
          state     <= S_LOAD;
        end
        S_LOAD: begin
          idx   <= '0;
          cnt   <= '0;
          state <= S_OP;
        end
        S_OP: begin
          if (!op_end) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (!last_op) idx <= idx + 1'b1;
            else if (!addr_expire) idx <= '0;
            else if (elem != LAST_ELEM) begin
              elem  <= elem + 1'b1;
              state <= S_LOAD;
            end else state <= S_FLUSH;
          end
        end
        S_FLUSH: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_write_has_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_ce);
  a_r3_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ce && !ram_we && rlat_q != '0) |=> !ram_ce);
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !run) |=> fail);
  a_r5_bits_only_grow: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((fail_bits & $past(fail_bits)) == $past(fail_bits)));
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  a_r7_fast_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fast_y));
  a_r2_no_step_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!addr_step && !ram_ce));
endmodule

// File: tb/march_seq_engine_test.sv
module march_seq_engine_test;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, fast_sel = 1'b0;
  logic [3:0] seed = '0, rd_lat = '0, wr_lat = '0;
  logic fast_y, addr_load, addr_down, addr_step, addr_expire;
  logic ram_ce, ram_we, busy, done, pass, fail;
  logic [63:0] ram_wdata, ram_rdata, fail_bits;

  int total = 0, bad = 0;
  always #2.5 clk = ~clk;

  march_seq_engine uut (.*);

  localparam logic [63:0] JUNK = 64'hA5A5_5A5A_F00F_0FF0;
  logic [63:0] mem [16];
  logic [63:0] pipe [16];
  logic [3:0]  c = '0;
  logic [3:0]  t_seed = '0, t_rl = '0;
  logic        f_en = 1'b0, f_val = 1'b0;
  logic [3:0]  f_addr = '0;
  logic [63:0] f_mask = '0;
  int n_rd = 0, n_wr = 0, n_badw = 0, n_load = 0;
  logic [5:0] dirs = '0;

  wire [3:0] paddr = fast_y ? c : {c[1:0], c[3:2]};
  assign addr_expire = addr_down ? (c == 4'd0) : (c == 4'd15);
  assign ram_rdata   = pipe[t_rl];

  function automatic logic [63:0] rep(input logic [3:0] s);
    return {16{s}};
  endfunction

  function automatic logic [63:0] rd_word(input logic [3:0] a);
    logic [63:0] w = mem[a];
    if (f_en && a == f_addr) w = f_val ? (w | f_mask) : (w & ~f_mask);
    return w;
  endfunction

  always @(posedge clk) begin
    for (int i = 15; i > 0; i--) pipe[i] <= pipe[i-1];
    pipe[0] <= (ram_ce && !ram_we) ? rd_word(paddr) : JUNK;
    if (ram_ce && ram_we) begin
      mem[paddr] <= ram_wdata;
      n_wr <= n_wr + 1;
      if (ram_wdata != rep(t_seed) && ram_wdata != ~rep(t_seed)) n_badw <= n_badw + 1;
    end
    if (ram_ce && !ram_we) n_rd <= n_rd + 1;
    if (addr_load) begin
      c <= addr_down ? 4'd15 : 4'd0;
      dirs <= {dirs[4:0], addr_down};
      n_load <= n_load + 1;
    end else if (addr_step) c <= addr_down ? c - 1'b1 : c + 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_test(input logic [3:0] s, input logic [3:0] rl, input logic [3:0] wl,
                          input logic fy, input logic fe, input logic [3:0] fa,
                          input int fb, input logic fv, input bit disturb);
    int bc = 0, cyc = 0, exp_bc;
    @(negedge clk);
    seed = s; rd_lat = rl; wr_lat = wl; fast_sel = fy;
    t_seed = s; t_rl = rl;
    f_en = fe; f_addr = fa; f_mask = 64'd1 << fb; f_val = fv;
    n_rd = 0; n_wr = 0; n_badw = 0; n_load = 0; dirs = '0;
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    while (!done && cyc < 20000) begin
      if (busy) bc++;
      cyc++;
      if (disturb && cyc == 40) begin
        run = 1'b1; seed = ~s; rd_lat = rl + 4'd3; wr_lat = wl + 4'd5; fast_sel = ~fy;
      end
      if (disturb && cyc == 41) run = 1'b0;
      @(negedge clk);
    end
    chk(cyc < 20000, "watchdog", cyc, 20000);
    exp_bc = 7 + 16 * (9 * (rl + 1) + 5 * (wl + 1));
    chk(bc == exp_bc, "R3 busy cycles", bc, exp_bc);
    chk(n_rd == 144, "R2 read count", n_rd, 144);
    chk(n_wr == 80, "R2 write count", n_wr, 80);
    chk(n_load == 6 && dirs == 6'b000110, "R2 element directions", dirs, 6'b000110);
    chk(n_badw == 0, "R1 write pattern", n_badw, 0);
    chk(mem[fa] == rep(s), "R1 final word", mem[fa], rep(s));
    chk(fail == fe, "R5 fail flag (R4 compare timing)", fail, fe);
    chk(fail_bits == (fe ? f_mask : 64'd0), "R5 fail bits", fail_bits, fe ? f_mask : 64'd0);
    chk(pass == !fe, "R5 pass", pass, !fe);
    chk(fast_y == fy, "R8 fast select (R7 ignored change)", fast_y, fy);
    repeat (3) @(negedge clk);
    chk(done && !busy, "R6 done holds", {busy, done}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; pipe[i] = JUNK; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !pass && fail_bits == 0 && !ram_ce, "R9 reset state",
        {busy, done, fail, pass, ram_ce}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_test(4'h0, 4'd0, 4'd0, 1'b1, 1'b0, 4'd0, 0, 1'b0, 1'b0);
    run_test(4'hF, 4'd15, 4'd15, 1'b0, 1'b0, 4'd7, 0, 1'b0, 1'b1);
    run_test(4'h6, 4'd0, 4'd0, 1'b0, 1'b1, 4'd0, 0, 1'b1, 1'b0);
    run_test(4'h9, 4'd2, 4'd1, 1'b1, 1'b1, 4'd15, 63, 1'b0, 1'b1);
    @(negedge clk);
    seed = 4'h3; rd_lat = 4'd1; wr_lat = 4'd1; t_seed = 4'h3; t_rl = 4'd1; run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fail && fail_bits == 0 && !ram_ce, "R9 mid-test reset",
        {busy, done, fail, ram_ce}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      run_test(4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
               4'($urandom), int'($urandom % 64), 1'($urandom), 1'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule